// File: doc/BRIEF.md
# Transmit Word Unpacker with Length Commands

This block sits between host software and the transmit side of an Ethernet MAC. Software writes 32-bit data words into a data queue and then writes a single command word into a separate command queue. The command gives the frame length in bytes and the byte lane where the frame begins inside its first word. The command is written last, so a frame is never started before all of its data is present.

The block takes one command at a time and turns the matching data words into a byte stream with a valid/ready handshake. It marks the first and last byte of each frame. Unused lanes at either end of the frame are skipped, and the next frame always begins on a new word. A live word count lets software work out the free space in the data queue. A full queue drops further writes and raises a sticky overflow flag. A synchronous flush empties both queues and abandons any frame in progress.

Top module: `tx_word_unpacker`

## Requirements
- R1: While reset is applied, and on leaving it, `byte_valid` is 0, `data_count` is 0 and `overflow` is 0.
- R2: `data_count` equals the number of data words held. An accepted write adds one, and each word the unpacker retires subtracts one.
- R3: The command word holds the length in bytes in bits 15:0 and the start lane (0 to 3) in bits 17:16. Bits 31:18 are ignored. Bytes leave in little-endian lane order, with lane n at data bits 8n+7:8n, starting at the start lane of the first word.
- R4: Exactly `length` bytes are emitted for a nonzero length. `byte_first` is 1 on the first byte only and `byte_last` is 1 on the final byte only. The cycle after the final byte is accepted, `byte_valid` is 0.
- R5: A frame retires exactly (length + start + 3) >> 2 data words. Lanes after the final byte are discarded, and the following frame starts with the next word.
- R6: No byte is emitted until a command is written, even when data words are already held.
- R7: While `byte_valid` is 1 and `byte_ready` is 0, `byte_valid` stays 1 and `byte_data` and `byte_last` hold their values.
- R8: A data write while 16 words are held is dropped, and `data_count` stays at 16. The same applies to a command write while 4 commands are held. Either drop sets `overflow`, which stays 1 until a flush.
- R9: While `flush` is 1, both queues are emptied, the frame in progress is abandoned and `overflow` is cleared. The cycle after flush, `byte_valid` is 0 and `data_count` is 0.
- R10: A zero-length command emits no byte. It retires one word if its start lane is nonzero and none if it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Synchronous clear of both queues and of the frame in progress |
| data_wr | input | 1 | Write strobe for a data word |
| data_in | input | 32 | Data word |
| cmd_wr | input | 1 | Write strobe for a command word |
| cmd_in | input | 32 | Command: length in 15:0, start lane in 17:16 |
| data_count | output | 5 | Number of data words held |
| overflow | output | 1 | Sticky flag for a dropped write |
| byte_valid | output | 1 | Byte output valid |
| byte_ready | input | 1 | Byte output accepted by the sink |
| byte_data | output | 8 | Output byte |
| byte_first | output | 1 | Marks the first byte of a frame |
| byte_last | output | 1 | Marks the last byte of a frame |

## Verification
Most internal faults show at the ports within the frame they affect. A wrong lane counter or start offset puts a wrong byte into the compared stream. A wrong remaining-byte count moves `byte_last` or merges two frames. An early or late word retirement leaves `data_count` off by one once the queue is quiet. This count is compared after every drain, including a drain that leaves a later frame's words waiting. A stall that is not held shows up the cycle after `byte_ready` is low. Flush and overflow faults show in `data_count`, `overflow` and `byte_valid` one cycle after the triggering write or flush.

// File: rtl/txu_pkg.sv
package txu_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int LEN_W  = 16;
  localparam int CMD_W  = LEN_W + LANE_W;

  typedef struct packed {
    logic [LANE_W-1:0] start;
    logic [LEN_W-1:0]  len;
  } tx_cmd_t;

  typedef enum logic [1:0] {
    UNPK_IDLE = 2'd0,
    UNPK_SEND = 2'd1,
    UNPK_DROP = 2'd2
  } unpk_state_e;
endpackage

// File: rtl/txu_rst_sync.sv
module txu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/txu_sync_fifo.sv
module txu_sync_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic [WIDTH-1:0]               wdata,
  input  logic                           pop,
  output logic [WIDTH-1:0]               rdata,
  output logic                           empty,
  output logic                           full,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr_q];
  assign count   = cnt_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_d = ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);  // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count)));  // R8
endmodule

// File: rtl/txu_unpacker.sv
module txu_unpacker
  import txu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cmd_valid,
  input  tx_cmd_t           cmd,
  output logic              cmd_pop,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic              word_pop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_first,
  output logic              out_last
);
  unpk_state_e       state_q, state_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              first_q, first_d;
  logic [7:0]        lane_byte [LANES];
  logic              sending, fire, final_byte;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = word[g*8 +: 8];
  end

  assign sending    = (state_q == UNPK_SEND);
  assign final_byte = (rem_q == LEN_W'(1));
  assign out_valid  = sending && word_valid;
  assign out_byte   = lane_byte[lane_q];
  assign out_first  = sending && first_q;
  assign out_last   = sending && final_byte;
  assign fire       = out_valid && out_ready;

  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    lane_d   = lane_q;
    first_d  = first_q;
    cmd_pop  = 1'b0;
    word_pop = 1'b0;
    case (state_q)
      UNPK_IDLE: begin
        if (cmd_valid) begin
          cmd_pop = 1'b1;
          rem_d   = cmd.len;
          lane_d  = cmd.start;
          first_d = 1'b1;
          if (cmd.len != '0)        state_d = UNPK_SEND;
          else if (cmd.start != '0) state_d = UNPK_DROP;
        end
      end
      UNPK_SEND: begin
        if (fire) begin
          rem_d   = rem_q - 1'b1;
          lane_d  = lane_q + 1'b1;
          first_d = 1'b0;
          if (final_byte) begin
            word_pop = 1'b1;
            state_d  = UNPK_IDLE;
          end else if (lane_q == LANE_W'(LANES - 1)) begin
            word_pop = 1'b1;
          end
        end
      end
      UNPK_DROP: begin
        if (word_valid) begin
          word_pop = 1'b1;
          state_d  = UNPK_IDLE;
        end
      end
      default: state_d = UNPK_IDLE;
    endcase
    if (flush) begin
      state_d  = UNPK_IDLE;
      cmd_pop  = 1'b0;
      word_pop = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UNPK_IDLE;
      rem_q   <= '0;
      lane_q  <= '0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      lane_q  <= lane_d;
      first_q <= first_d;
    end
  end

  AST_LAST_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last && !flush) |=> !out_valid);  // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));  // R7
endmodule

// File: rtl/tx_word_unpacker.sv
module tx_word_unpacker
  import txu_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              data_wr,
  input  logic [31:0]                       data_in,
  input  logic                              cmd_wr,
  input  logic [31:0]                       cmd_in,
  output logic [$clog2(DATA_DEPTH+1)-1:0]   data_count,
  output logic                              overflow,
  output logic                              byte_valid,
  input  logic                              byte_ready,
  output logic [7:0]                        byte_data,
  output logic                              byte_first,
  output logic                              byte_last
);
  localparam int CCW = $clog2(CMD_DEPTH + 1);

  logic              rst_sync_n;
  logic [WORD_W-1:0] head_word;
  logic              data_empty, data_full, data_pop;
  logic [CMD_W-1:0]  cmd_head;
  logic              cmd_empty, cmd_full, cmd_pop;
  logic [CCW-1:0]    cmd_count;
  logic              ovf_q, ovf_d;
  logic              unused_cmd;

  assign unused_cmd = ^{cmd_in[31:CMD_W], cmd_count};

  txu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  txu_sync_fifo #(.WIDTH(WORD_W), .DEPTH(DATA_DEPTH)) u_data_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .flush (flush),
    .push  (data_wr),
    .wdata (data_in),
    .pop   (data_pop),
    .rdata (head_word),
    .empty (data_empty),
    .full  (data_full),
    .count (data_count)
  );

  txu_sync_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .flush (flush),
    .push  (cmd_wr),
    .wdata (cmd_in[CMD_W-1:0]),
    .pop   (cmd_pop),
    .rdata (cmd_head),
    .empty (cmd_empty),
    .full  (cmd_full),
    .count (cmd_count)
  );

  txu_unpacker u_unpacker (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flush      (flush),
    .cmd_valid  (!cmd_empty),
    .cmd        (tx_cmd_t'(cmd_head)),
    .cmd_pop    (cmd_pop),
    .word_valid (!data_empty),
    .word       (head_word),
    .word_pop   (data_pop),
    .out_valid  (byte_valid),
    .out_ready  (byte_ready),
    .out_byte   (byte_data),
    .out_first  (byte_first),
    .out_last   (byte_last)
  );

  always_comb begin
    ovf_d = ovf_q;
    if (flush)                                            ovf_d = 1'b0;
    else if ((data_wr && data_full) || (cmd_wr && cmd_full)) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovf_q <= 1'b0;
    else             ovf_q <= ovf_d;
  end

  assign overflow = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (overflow && !flush) |=> overflow);  // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> (data_count == '0 && !overflow && !byte_valid));  // R9
endmodule

// File: tb/tx_word_unpacker_bench.sv
module tx_word_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n, flush, data_wr, cmd_wr, byte_ready;
  logic [31:0] data_in, cmd_in;
  logic [4:0]  data_count;
  logic        overflow, byte_valid, byte_first, byte_last;
  logic [7:0]  byte_data;

  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  int          ready_mode = 0;
  logic [9:0]  sb [$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tx_word_unpacker u_tx_word_unpacker (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .data_wr(data_wr), .data_in(data_in), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
    .data_count(data_count), .overflow(overflow),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .byte_first(byte_first), .byte_last(byte_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: owns byte_ready, pops the scoreboard on each handshake.
  initial begin
    logic       prev_stall = 1'b0;
    logic [8:0] prev_out = '0;
    logic [9:0] e;
    byte_ready = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      byte_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (lfsr[1] | lfsr[4]) : 1'b0;
      #1;
      if (rst_n === 1'b1 && !flush) begin
        if (prev_stall) begin  // R7
          chk(byte_valid && {byte_last, byte_data} == prev_out, "R7 stall hold",
              {byte_valid, byte_last, byte_data}, {1'b1, prev_out});
        end
        if (byte_valid && byte_ready) begin
          if (sb.size() == 0) begin  // R6
            chk(1'b0, "R6 unexpected byte", byte_data, -1);
          end else begin
            e = sb.pop_front();  // R3 R4
            chk({byte_first, byte_last, byte_data} == e, "R3 R4 byte stream",
                {byte_first, byte_last, byte_data}, e);
          end
        end
        prev_stall = byte_valid && !byte_ready;
      end else begin
        prev_stall = 1'b0;
      end
      prev_out = {byte_last, byte_data};
    end
  end

  task automatic push_word(input logic [31:0] w);
    data_wr = 1'b1; data_in = w;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  function automatic logic [7:0] fbyte(input int base, input int k);
    return 8'(base + k * 7);
  endfunction

  // Pushes the words of a frame and its expected bytes; returns word count.
  task automatic frame_words(input int len, input int off, input int base, output int nw);
    logic [31:0] w;
    nw = (len + off + 3) >> 2;
    for (int i = 0; i < nw; i++) begin
      w = 32'hA5A5_A5A5;
      for (int l = 0; l < 4; l++) begin
        int p = i * 4 + l;
        if (p >= off && p < off + len) w[l*8 +: 8] = fbyte(base, p - off);
      end
      push_word(w);
    end
    for (int k = 0; k < len; k++)
      sb.push_back({k == 0, k == len - 1, fbyte(base, k)});
  endtask

  task automatic frame_cmd(input int len, input int off);
    cmd_wr = 1'b1;
    cmd_in = {14'h3FFF, 2'(off), 16'(len)};  // R3 upper bits set, must be ignored
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic send_frame(input int len, input int off, input int base);
    int nw;
    frame_words(len, off, base, nw);
    frame_cmd(len, off);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    repeat (3) @(negedge clk);
    flush = 1'b0;
    sb.delete();
    #1;
  endtask

  initial begin
    int nw, nwb;
    rst_n = 1'b0; flush = 1'b0; data_wr = 1'b0; cmd_wr = 1'b0;
    data_in = '0; cmd_in = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(byte_valid == 1'b0, "R1 valid in reset", byte_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(byte_valid == 1'b0, "R1 valid after reset", byte_valid, 0);
    chk(data_count == 0, "R1 count after reset", data_count, 0);
    chk(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
    @(negedge clk);

    // R6: words held without a command produce nothing
    frame_words(9, 1, 8'h10, nw);
    repeat (8) @(negedge clk);
    #1;
    chk(byte_valid == 1'b0, "R6 no output before command", byte_valid, 0);
    chk(data_count == 5'(nw), "R2 count of held words", data_count, nw);
    @(negedge clk);
    frame_cmd(9, 1);
    drain();
    chk(data_count == 0, "R5 words retired after frame", data_count, 0);
    @(negedge clk);

    // R3 R4 R7: varied lengths and lanes under random backpressure
    ready_mode = 1;
    send_frame(1, 0, 8'h21);
    send_frame(4, 0, 8'h32);
    send_frame(5, 3, 8'h43);
    drain();
    send_frame(8, 2, 8'h54);
    send_frame(13, 1, 8'h65);
    send_frame(2, 3, 8'h76);
    drain();
    chk(data_count == 0, "R5 count after mixed frames", data_count, 0);
    @(negedge clk);

    // R5: tail lanes discarded, next frame words stay queued
    ready_mode = 0;
    frame_words(6, 3, 8'h87, nw);
    frame_cmd(6, 3);
    frame_words(7, 0, 8'h98, nwb);
    while (sb.size() != 7) @(negedge clk);
    repeat (5) @(negedge clk);
    #1;
    chk(data_count == 5'(nwb), "R5 next frame words untouched", data_count, nwb);
    @(negedge clk);
    frame_cmd(7, 0);
    drain();
    chk(data_count == 0, "R5 second frame retired", data_count, 0);
    @(negedge clk);

    // R10: zero-length commands
    frame_cmd(0, 0);
    repeat (5) @(negedge clk);
    #1;
    chk(byte_valid == 1'b0 && data_count == 0, "R10 zero length lane 0", byte_valid, 0);
    @(negedge clk);
    push_word(32'h1234_5678);
    frame_cmd(0, 2);
    repeat (5) @(negedge clk);
    #1;
    chk(data_count == 0, "R10 zero length lane 2 retires one word", data_count, 0);
    chk(byte_valid == 1'b0, "R10 zero length emits nothing", byte_valid, 0);
    @(negedge clk);

    // R8: overflow
    for (int i = 0; i < 18; i++) push_word(32'(i));
    #1;
    chk(data_count == 16, "R8 count saturates at depth", data_count, 16);
    chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    @(negedge clk);
    do_flush();
    chk(data_count == 0, "R9 flush empties data", data_count, 0);
    chk(overflow == 1'b0, "R9 flush clears overflow", overflow, 0);
    @(negedge clk);

    // R9: flush mid-frame
    ready_mode = 2;
    send_frame(20, 1, 8'hB0);
    repeat (4) @(negedge clk);
    #1;
    chk(byte_valid == 1'b1, "R9 frame pending before flush", byte_valid, 1);
    @(negedge clk);
    do_flush();
    chk(byte_valid == 1'b0, "R9 frame abandoned", byte_valid, 0);
    chk(data_count == 0, "R9 count after flush", data_count, 0);
    @(negedge clk);
    ready_mode = 0;
    send_frame(3, 2, 8'hC7);
    drain();
    chk(data_count == 0, "R9 clean frame after flush", data_count, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule